// File: doc/BRIEF.md
# Seventeen-Bit Word Packer

This block collects a stream of 17-bit compressed words, each marked by a valid flag in the capture clock domain. It holds them in a small buffer built from flip-flops. When the seventh word of a group arrives, the block assembles a 128-bit beat and presents it with a one-cycle valid strobe to the write port of a downstream FIFO. The seven words fill 119 bits, and the nine bits above them are always zero.

The downstream FIFO reports whether it can take a write. The packer never stalls its input, because the capture stream cannot be paused. A beat that is presented while the FIFO cannot accept it is lost. The loss is recorded in a sticky overflow flag that stays set until reset. A flush input closes a partly filled group, so that the tail of a capture can be written out. The empty slots of that group become all-zero words.

Top module: `wpk_packer`

## Requirements
- R1: While `rst` is high, at the first clock edge the block clears its buffer, and `out_valid`, `overflow` and `out_data` read zero after that edge.
- R2: The clock edge that accepts the seventh word of a group raises `out_valid` for exactly one cycle after that edge. No beat is produced while a group is incomplete, unless a flush closes it.
- R3: In an emitted beat, the k-th word of the group (k = 0 for the first accepted) occupies `out_data[17k+16:17k]`.
- R4: Bits `out_data[127:119]` are zero in every emitted beat.
- R5: A cycle with `in_valid` low takes no slot, and its `in_word` value appears in no beat.
- R6: A word accepted in the same cycle that `out_valid` is high is kept, and becomes word 0 of the next group. Continuous input loses no word.
- R7: When `flush` is high, the group is closed at that edge, including any word accepted at the same edge. Its empty slots are zero. A flush with an empty buffer and no valid word produces no beat.
- R8: When `out_valid` is high while `out_ready` is low, `overflow` is high from the next cycle on and stays high until reset. Packing continues regardless of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 17 | Compressed input word |
| flush | input | 1 | Close the current partial group |
| out_ready | input | 1 | Downstream FIFO can accept a write (not full) |
| out_valid | output | 1 | Write strobe for the packed beat |
| out_data | output | 128 | Packed beat |
| overflow | output | 1 | Sticky flag: a beat was presented while not ready |

## Verification
The bench aims at the seam between groups. These cases include a seventh word followed at once by a new first word, a flush that coincides with an incoming word, and a flush that coincides with group completion. A design that resets its fill count one cycle late would drop or misplace the word that starts the next group. A design that ignores the same-cycle word on flush would emit a beat that is one word short. The bench also checks that the idle data bus never leaks into a slot and that an empty flush stays silent. It drives a refused beat and confirms that the overflow flag sets and then survives later accepted traffic. A design that cleared the flag on a good write, or that stalled packing on backpressure, would diverge from the model.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  // Why the slot buffer closes a group this cycle.
  typedef enum logic [1:0] {
    EMIT_NONE  = 2'd0,
    EMIT_FULL  = 2'd1,
    EMIT_FLUSH = 2'd2
  } emit_kind_e;

  function automatic logic is_emit(emit_kind_e k);
    return k != EMIT_NONE;
  endfunction
endpackage

// File: rtl/wpk_slot_buf.sv
module wpk_slot_buf
  import wpk_pkg::*;
#(
  parameter int unsigned WORD_W = 17,
  parameter int unsigned SLOTS  = 7,
  localparam int unsigned USED_W = WORD_W * SLOTS,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              flush,
  output emit_kind_e        emit_kind,
  output logic [USED_W-1:0] group
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0]  fill_q;
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic              full_hit;
  logic              flush_hit;

  always_comb begin
    full_hit  = in_valid && (fill_q == LAST);
    flush_hit = flush && ((fill_q != '0) || in_valid);
    if (full_hit)       emit_kind = EMIT_FULL;
    else if (flush_hit) emit_kind = EMIT_FLUSH;
    else                emit_kind = EMIT_NONE;
  end

  // Slots below the fill level come from storage, the slot at the fill
  // level takes the word arriving now, and the rest read as zero.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);

    assign group[i*WORD_W +: WORD_W] =
      (IDX < fill_q)                ? slot_q[i] :
      ((IDX == fill_q) && in_valid) ? in_word   : '0;

    always_ff @(posedge clk) begin
      if (rst)
        slot_q[i] <= '0;
      else if (in_valid && (fill_q == IDX) && !is_emit(emit_kind))
        slot_q[i] <= in_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fill_q <= '0;
    else if (is_emit(emit_kind))
      fill_q <= '0;
    else if (in_valid)
      fill_q <= fill_q + 1'b1;
  end
endmodule

// File: rtl/wpk_out_stage.sv
module wpk_out_stage
  import wpk_pkg::*;
#(
  parameter int unsigned OUT_W  = 128,
  parameter int unsigned USED_W = 119
) (
  input  logic              clk,
  input  logic              rst,
  input  emit_kind_e        emit_kind,
  input  logic [USED_W-1:0] group,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= is_emit(emit_kind);
      if (is_emit(emit_kind))
        out_data <= OUT_W'(group);
    end
  end
endmodule

// File: rtl/wpk_sticky_flag.sv
module wpk_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/wpk_packer.sv
module wpk_packer
  import wpk_pkg::*;
#(
  parameter int unsigned WORD_W = 17,
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned OUT_W  = 128,
  localparam int unsigned USED_W = WORD_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              flush,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              overflow
);
  emit_kind_e        emit_kind;
  logic [USED_W-1:0] group;
  logic              lost_beat;

  wpk_slot_buf #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .flush(flush), .emit_kind(emit_kind), .group(group)
  );

  wpk_out_stage #(.OUT_W(OUT_W), .USED_W(USED_W)) u_out (
    .clk(clk), .rst(rst), .emit_kind(emit_kind), .group(group),
    .out_valid(out_valid), .out_data(out_data)
  );

  assign lost_beat = out_valid && !out_ready;

  wpk_sticky_flag u_ovf (
    .clk(clk), .rst(rst), .set(lost_beat), .flag(overflow)
  );
endmodule

// File: rtl/wpk_packer_chk.sv
module wpk_packer_chk #(
  parameter int unsigned OUT_W  = 128,
  parameter int unsigned USED_W = 119
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             flush,
  input logic             out_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             overflow
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow));

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[OUT_W-1:USED_W] == '0));

  p_idle_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !flush) |=> !out_valid);

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> overflow);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(out_valid && !out_ready));
endmodule

bind wpk_packer wpk_packer_chk #(.OUT_W(OUT_W), .USED_W(USED_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .flush(flush),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .overflow(overflow)
);

// File: tb/wpk_packer_tb_top.sv
module wpk_packer_tb_top;
  localparam int W = 17;
  localparam int N = 7;
  localparam int OW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_word = '0;
  logic          flush = 1'b0;
  logic          out_ready = 1'b1;
  logic          out_valid;
  logic [OW-1:0] out_data;
  logic          overflow;

  always #4 clk = ~clk;

  wpk_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .flush(flush), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .overflow(overflow)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    cyc    = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [W-1:0]  mq[$];
  logic          exp_v = 1'b0;
  logic [OW-1:0] exp_d = '0;
  logic          exp_o = 1'b0;

  always @(posedge clk) begin
    logic          ovf_n;
    logic          emit;
    logic [OW-1:0] d;
    if (rst) begin
      mq.delete();
      exp_v = 1'b0;
      exp_d = '0;
      exp_o = 1'b0;
    end else begin
      ovf_n = exp_o | (exp_v & ~out_ready);
      if (in_valid) mq.push_back(in_word);
      emit = (mq.size() == N) || (flush && mq.size() > 0);
      if (emit) begin
        d = '0;
        foreach (mq[k]) d[k*W +: W] = mq[k];
        exp_d = d;
        mq.delete();
      end
      exp_v = emit;
      exp_o = ovf_n;
    end
  end

  task automatic check(bit ok, string what, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      check(out_valid === exp_v, "out_valid", OW'(out_valid), OW'(exp_v));
      check(overflow === exp_o, "overflow", OW'(overflow), OW'(exp_o));
      if (exp_v || rst)
        check(out_data === exp_d, "out_data", out_data, exp_d);
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++;
      fails++;
      $display("FAIL %s watchdog: actual %0d cycles expected under 100000", cur_req, cyc);
      finish_up();
    end
  end

  task automatic drive(bit v, logic [W-1:0] w, bit f);
    in_valid = v;
    in_word  = w;
    flush    = f;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4: one full group of distinct words
    cur_req = "R3";
    for (int i = 0; i < N; i++) drive(1'b1, W'(17'h10001 + i * 17'h0123), 1'b0);
    drive(1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b0);

    // R5: idle cycles carry garbage on the data bus
    cur_req = "R5";
    for (int i = 0; i < N; i++) begin
      drive(1'b0, 17'h1ffff, 1'b0);
      drive(1'b1, W'(17'h00a00 + i), 1'b0);
    end
    drive(1'b0, 17'h15555, 1'b0);

    // R6: continuous stream across three groups
    cur_req = "R6";
    for (int i = 0; i < 3 * N; i++) drive(1'b1, W'(17'h1f000 - i * 3), 1'b0);
    drive(1'b0, '0, 1'b0);

    // R7: partial flush, flush with same-cycle word, empty flush, flush at full
    cur_req = "R7";
    for (int i = 0; i < 3; i++) drive(1'b1, W'(17'h0beef + i), 1'b0);
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b0);
    drive(1'b1, 17'h12345, 1'b0);
    drive(1'b1, 17'h0abcd, 1'b1);
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b0);
    for (int i = 0; i < N - 1; i++) drive(1'b1, W'(i + 1), 1'b0);
    drive(1'b1, 17'h1ffff, 1'b1);
    drive(1'b1, 17'h00077, 1'b1);
    drive(1'b0, '0, 1'b0);

    // R8: refused beat sets overflow; it survives accepted traffic
    cur_req = "R8";
    out_ready = 1'b0;
    for (int i = 0; i < N; i++) drive(1'b1, W'(17'h05050 + i), 1'b0);
    drive(1'b0, '0, 1'b0);
    out_ready = 1'b1;
    for (int i = 0; i < 2 * N; i++) drive(1'b1, W'(17'h0c000 + i), 1'b0);
    drive(1'b0, '0, 1'b0);

    // R1: reset clears the sticky flag and the buffer
    cur_req = "R1";
    for (int i = 0; i < 3; i++) drive(1'b1, W'(17'h0dead + i), 1'b0);
    rst = 1'b1;
    drive(1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b0);
    rst = 1'b0;

    // R2: mixed traffic with flushes and backpressure
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      out_ready = ($urandom % 8) != 0;
      drive(($urandom % 4) != 0, W'($urandom), ($urandom % 23) == 0);
    end
    drive(1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b0);
    finish_up();
  end
endmodule